// File: doc/BRIEF.md
# Pipelined Bitmap Prefix-Count Address Generator

This block turns a 16-bit occupancy bitmap, a 4-bit slot position and an 18-bit base pointer into a memory address. The address is the base plus the number of set bits that lie strictly before the chosen slot. Slots are numbered from the most significant bit: slot 0 is bit 15 and slot 15 is bit 0. A trie-walking search engine uses it to find a child record or a result record inside a packed array. The array holds only the entries that are present, so an entry's offset equals the count of present entries ahead of it.

The bitmap is split into a lead slice (bits 15:8, slots 0 to 7) and a trail slice (bits 7:0, slots 8 to 15). Both slices are looked up in the same cycle in a dual-read table of partial counts. Each table address is the 8 slice bits plus a 3-bit field that says how many leading bits of the slice to count. The table is built at elaboration time. Its outputs are registered, and the slot value forces a slice's address or clears its count where the 3-bit field cannot express the case. The two counts and the base are then summed in a registered adder stage. The input, the table and the adder are each registered once, and the block accepts a new request every cycle.

Top module: `pfx_addr_gen`

## Requirements
- R1: `out_addr` equals `in_base` plus the number of ones among bitmap bits 15 down to 16-`in_pos` (that is, slots 0 to `in_pos`-1, with slot s being bit 15-s).
- R2: With `in_pos` = 0 the result equals `in_base`, whatever the bitmap holds.
- R3: With `in_pos` from 1 to 8, bits 7:0 of the bitmap have no effect on the result.
- R4: With `in_pos` from 9 to 15, all eight of bits 15:8 are counted, plus the trail bits from bit 7 down to bit 16-`in_pos`.
- R5: The sum wraps modulo 2^18.
- R6: `out_valid` rises exactly 3 clock edges after the edge that samples `in_valid` high, and `out_valid` is low in any cycle whose request slot 3 edges earlier was empty.
- R7: Requests on consecutive cycles produce results on consecutive cycles, in the same order.
- R8: While reset is held and after it is released with no request, `out_valid` and `out_addr` are both 0.
- R9: Bits at slot `in_pos` and at higher slot numbers do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| in_valid | input | 1 | Request present this cycle |
| in_map | input | 16 | Occupancy bitmap, slot 0 at bit 15 |
| in_pos | input | 4 | Slot whose predecessors are counted |
| in_base | input | 18 | Base pointer |
| out_valid | output | 1 | Result present this cycle |
| out_addr | output | 18 | Base plus prefix count |

## Verification
A request is sampled at one rising edge. Its address and valid appear after the third rising edge: one edge for the input register, one for the table read and one for the sum. The single-request tasks drive on the falling edge and check `out_valid` low after the second edge, high with the expected address after the third, and low again after the fourth. The streaming task drives a new request on each falling edge and, on the same edge, compares the output with the request issued three cycles before. Every expected address comes from a bit-by-bit count in the bench.

// File: rtl/pfx_cnt_pkg.sv
package pfx_cnt_pkg;
  localparam int unsigned SLICE_W = 8;
  localparam int unsigned SEL_W   = $clog2(SLICE_W);
  localparam int unsigned CNT_W   = $clog2(SLICE_W + 1);
  localparam int unsigned MAP_W   = 2 * SLICE_W;
  localparam int unsigned POS_W   = $clog2(MAP_W);
  localparam int unsigned ROM_AW  = SLICE_W + SEL_W;

  typedef logic [CNT_W-1:0]   cnt_t;
  typedef logic [SLICE_W-1:0] slice_t;
  typedef logic [SEL_W-1:0]   sel_t;

  // Ones among the leading (k+1) bits of v, MSB first.
  function automatic cnt_t lead_ones(slice_t v, sel_t k);
    cnt_t c;
    c = '0;
    for (int j = 0; j < int'(SLICE_W); j++) begin
      if (j <= int'(k) && v[SLICE_W-1-j]) c = c + cnt_t'(1);
    end
    return c;
  endfunction
endpackage

// File: rtl/bytecount_rom.sv
module bytecount_rom
  import pfx_cnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ROM_AW-1:0] addr_a,
  input  logic              clr_a,
  input  logic [ROM_AW-1:0] addr_b,
  input  logic              clr_b,
  output cnt_t              cnt_a,
  output cnt_t              cnt_b
);
  localparam int unsigned DEPTH = 1 << ROM_AW;

  function automatic logic [DEPTH*CNT_W-1:0] build_table();
    logic [DEPTH*CNT_W-1:0] t;
    logic [ROM_AW-1:0]      a;
    t = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      a = ROM_AW'(i);
      t[i*CNT_W +: CNT_W] = lead_ones(a[ROM_AW-1:SEL_W], a[SEL_W-1:0]);
    end
    return t;
  endfunction

  localparam logic [DEPTH*CNT_W-1:0] TABLE = build_table();

  cnt_t nxt_a, nxt_b;

  always_comb begin
    nxt_a = clr_a ? '0 : TABLE[addr_a*CNT_W +: CNT_W];
    nxt_b = clr_b ? '0 : TABLE[addr_b*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_a <= '0;
      cnt_b <= '0;
    end else if (en) begin
      cnt_a <= nxt_a;
      cnt_b <= nxt_b;
    end
  end

  // R2 / R3: a forced clear leaves a zero count on the next edge
  assert_clear_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr_a) |=> (cnt_a == '0));
  assert_clear_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr_b) |=> (cnt_b == '0));
  // R1: a slice count never exceeds the slice width
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_a <= cnt_t'(SLICE_W)) && (cnt_b <= cnt_t'(SLICE_W)));
endmodule

// File: rtl/addr_sum.sv
module addr_sum
  import pfx_cnt_pkg::*;
#(
  parameter int unsigned PTR_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [PTR_W-1:0] base_i,
  input  cnt_t             cnt_a,
  input  cnt_t             cnt_b,
  output logic             vld_o,
  output logic [PTR_W-1:0] addr_o
);
  logic [PTR_W-1:0] addr_nxt;

  always_comb begin
    addr_nxt = base_i + PTR_W'(cnt_a) + PTR_W'(cnt_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      addr_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) addr_o <= addr_nxt;
    end
  end

  // R5: the result lies within MAP_W-1 steps above the base, modulo 2^PTR_W
  assert_offset_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> (PTR_W'(addr_o - $past(base_i)) <= PTR_W'(MAP_W - 1)));
endmodule

// File: rtl/pfx_addr_gen.sv
module pfx_addr_gen
  import pfx_cnt_pkg::*;
#(
  parameter int unsigned PTR_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [15:0]      in_map,
  input  logic [3:0]       in_pos,
  input  logic [PTR_W-1:0] in_base,
  output logic             out_valid,
  output logic [PTR_W-1:0] out_addr
);
  // stage 0: input register
  logic             s0_vld;
  logic [MAP_W-1:0] s0_map;
  logic [POS_W-1:0] s0_pos;
  logic [PTR_W-1:0] s0_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_vld  <= 1'b0;
      s0_map  <= '0;
      s0_pos  <= '0;
      s0_base <= '0;
    end else begin
      s0_vld <= in_valid;
      if (in_valid) begin
        s0_map  <= in_map;
        s0_pos  <= in_pos;
        s0_base <= in_base;
      end
    end
  end

  // table address and clear forming from the slot value
  sel_t              lead_sel, trail_sel;
  logic              lead_clr, trail_clr;
  logic [ROM_AW-1:0] lead_addr, trail_addr;

  always_comb begin
    lead_sel   = s0_pos[POS_W-1] ? sel_t'(SLICE_W - 1)
                                 : sel_t'(s0_pos[SEL_W-1:0] - sel_t'(1));
    trail_sel  = sel_t'(s0_pos[SEL_W-1:0] - sel_t'(1));
    lead_clr   = (s0_pos == '0);
    trail_clr  = (s0_pos <= POS_W'(SLICE_W));
    lead_addr  = {s0_map[MAP_W-1:SLICE_W], lead_sel};
    trail_addr = {s0_map[SLICE_W-1:0], trail_sel};
  end

  // stage 1: registered table read, base and valid carried alongside
  cnt_t             lead_cnt, trail_cnt;
  logic             s1_vld;
  logic [PTR_W-1:0] s1_base;

  bytecount_rom u_rom (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (s0_vld),
    .addr_a (lead_addr),
    .clr_a  (lead_clr),
    .addr_b (trail_addr),
    .clr_b  (trail_clr),
    .cnt_a  (lead_cnt),
    .cnt_b  (trail_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_base <= '0;
    end else begin
      s1_vld <= s0_vld;
      if (s0_vld) s1_base <= s0_base;
    end
  end

  // stage 2: sum
  addr_sum #(.PTR_W(PTR_W)) u_sum (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (s1_vld),
    .base_i (s1_base),
    .cnt_a  (lead_cnt),
    .cnt_b  (trail_cnt),
    .vld_o  (out_valid),
    .addr_o (out_addr)
  );

  // R6: valid travels three edges
  assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##2 out_valid);
  assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##2 !out_valid);
  // R2: slot zero returns the base unchanged
  assert_pos_zero_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_pos == '0) |=> ##2 (out_addr == $past(in_base, 3)));
  // R3: for slots up to 8 the trail slice count is zero
  assert_trail_unused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_vld && s0_pos <= POS_W'(SLICE_W)) |=> (trail_cnt == '0));
endmodule

// File: tb/sim_pfx_addr_gen.sv
`timescale 1ns/1ps
module sim_pfx_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_map;
  logic [3:0]  in_pos;
  logic [17:0] in_base;
  logic        out_valid;
  logic [17:0] out_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pfx_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_map(in_map),
    .in_pos(in_pos), .in_base(in_base), .out_valid(out_valid), .out_addr(out_addr)
  );

  function automatic logic [17:0] ref_addr(logic [15:0] m, logic [3:0] p, logic [17:0] b);
    int c;
    c = 0;
    for (int j = 0; j < 16; j++) if (j < int'(p) && m[15-j]) c++;
    return b + 18'(c);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic single(string req, logic [15:0] m, logic [3:0] p, logic [17:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_map = m; in_pos = p; in_base = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_map = ~m; in_pos = ~p; in_base = ~b;
    @(posedge clk);
    @(negedge clk);
    check("R6 early", 32'(out_valid), 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R6 valid", 32'(out_valid), 32'd1);
    check(req, 32'(out_addr), 32'(ref_addr(m, p, b)));
    @(posedge clk);
    @(negedge clk);
    check("R6 drop", 32'(out_valid), 32'd0);
  endtask

  task automatic t_reset();
    check("R8 valid", 32'(out_valid), 32'd0);
    check("R8 addr", 32'(out_addr), 32'd0);
  endtask

  task automatic t_pos_zero();
    single("R2 full map", 16'hFFFF, 4'd0, 18'h12345);
    check("R2 base", 32'(out_addr), 32'h12345);
  endtask

  task automatic t_lead_only();
    logic [17:0] a1;
    single("R3 p8 ones", 16'hA5FF, 4'd8, 18'h00100);
    a1 = out_addr;
    check("R3 p8 value", 32'(a1), 32'h00104);
    single("R3 p8 zeros", 16'hA500, 4'd8, 18'h00100);
    check("R3 trail ignored", 32'(out_addr), 32'(a1));
    single("R3 p3", 16'hE0FF, 4'd3, 18'h00000);
    check("R3 p3 value", 32'(out_addr), 32'd3);
  endtask

  task automatic t_trail();
    single("R4 p15", 16'hFFFF, 4'd15, 18'h00000);
    check("R4 p15 value", 32'(out_addr), 32'd15);
    single("R4 p9", 16'h0080, 4'd9, 18'h00020);
    check("R4 p9 value", 32'(out_addr), 32'h21);
    single("R4 p12", 16'h0F50, 4'd12, 18'h00000);
    check("R4 p12 value", 32'(out_addr), 32'd6);
  endtask

  task automatic t_wrap();
    single("R5 wrap", 16'hFFFF, 4'd15, 18'h3FFFF);
    check("R5 wrap value", 32'(out_addr), 32'd14);
  endtask

  task automatic t_right_ignored();
    logic [17:0] a1;
    single("R9 a", 16'b10100_00000000000, 4'd5, 18'h00400);
    a1 = out_addr;
    single("R9 b", 16'b10100_11111111111, 4'd5, 18'h00400);
    check("R9 same", 32'(out_addr), 32'(a1));
    check("R9 value", 32'(out_addr), 32'h00402);
  endtask

  task automatic t_stream();
    logic [15:0] m [24];
    logic [3:0]  p [24];
    logic [17:0] b [24];
    logic [31:0] s;
    s = 32'h1F2E3D4C;
    for (int i = 0; i < 24; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      m[i] = s[15:0]; p[i] = s[19:16]; b[i] = {s[31:20], 6'(i)};
    end
    for (int i = 0; i < 27; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        check("R7 valid", 32'(out_valid), 32'd1);
        check("R1 stream", 32'(out_addr), 32'(ref_addr(m[i-3], p[i-3], b[i-3])));
      end
      if (i < 24) begin
        in_valid = 1'b1; in_map = m[i]; in_pos = p[i]; in_base = b[i];
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R6 stream end", 32'(out_valid), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_map = '0; in_pos = '0; in_base = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_pos_zero();
    t_lead_only();
    t_trail();
    t_wrap();
    t_right_ignored();
    t_stream();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule